// File: doc/BRIEF.md
# Two-Stage Thermal Shutdown Supervisor

This block watches two over-temperature comparator flags and a cool-down flag from an analog sensor. When the lower trip point (around 132 °C) is passed, it records a warning interrupt so that the host can reduce power dissipation. When the upper trip point (around 152 °C) is passed, it records a second interrupt. It also switches off the channel pull-up and pull-down current sources and clears both the channel output register and the flash-pulse enable register.

Recovery is asymmetric. The current sources come back by themselves once the sensor reports that the die has cooled below the recovery level (around 132 °C). The output and flash-enable registers stay at zero until the host writes them again. The live comparator states appear as two static status bits. The two stored interrupts drive an active-low interrupt pin, and an end-of-interrupt strobe clears them. All three sensor flags pass through a synchronizer of configurable depth before any logic uses them.

Top module: `thermal_supervisor`

## Requirements
- R1: After reset, `src_en_o` is 1, `out_q_o` and `flash_q_o` are all zero, both stored interrupts are 0 and `irq_n_o` is 1.
- R2: `warn_stat_o` and `crit_stat_o` follow `temp_warn_i` and `temp_crit_i` after SYNC_STAGES clock cycles, in both directions.
- R3: A 0-to-1 change of the synchronized stage-1 flag sets `warn_irq_o`. Stage 1 alone changes neither the current sources nor the output or flash registers.
- R4: A 0-to-1 change of the synchronized stage-2 flag sets `crit_irq_o`.
- R5: A stored interrupt is set only by a rising edge of its flag. After it is cleared while the flag stays high, it stays clear until the flag falls and rises again.
- R6: A one-cycle `eoi_i` pulse clears both stored interrupts. `irq_n_o` is 0 exactly while at least one stored interrupt is 1.
- R7: If a rising edge and `eoi_i` occur in the same cycle, the set wins and the interrupt stays stored.
- R8: While the synchronized stage-2 flag is 1, `src_en_o` drops to 0 and both `out_q_o` and `flash_q_o` are forced to zero.
- R9: Host writes to the output or flash register are ignored while the shutdown is active (`src_en_o` = 0).
- R10: The shutdown stays active until the synchronized cool-down flag is 1 while the stage-2 flag is 0. Only then does `src_en_o` return to 1.
- R11: After recovery, `out_q_o` and `flash_q_o` stay zero until the host writes them. A later write takes effect in the next cycle.
- R12: The cool-down flag has no effect on `src_en_o` or on the registers while no shutdown is active.
- R13: With no shutdown, a cycle with `out_we_i` = 1 loads `out_wdata_i` into `out_q_o`, and a cycle with `flash_we_i` = 1 loads `flash_wdata_i` into `flash_q_o`. Each register is written independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_warn_i | input | 1 | Stage-1 comparator, 1 above the lower trip point |
| temp_crit_i | input | 1 | Stage-2 comparator, 1 above the upper trip point |
| temp_cool_i | input | 1 | Recovery comparator, 1 below the recovery level |
| eoi_i | input | 1 | End-of-interrupt strobe |
| out_we_i | input | 1 | Output register write enable |
| out_wdata_i | input | NUM_CH | Output register write data |
| flash_we_i | input | 1 | Flash-enable register write enable |
| flash_wdata_i | input | NUM_CH | Flash-enable register write data |
| out_q_o | output | NUM_CH | Output register contents |
| flash_q_o | output | NUM_CH | Flash-enable register contents |
| src_en_o | output | 1 | Channel current sources enabled |
| warn_stat_o | output | 1 | Live stage-1 status |
| crit_stat_o | output | 1 | Live stage-2 status |
| warn_irq_o | output | 1 | Stored warning interrupt |
| crit_irq_o | output | 1 | Stored shutdown interrupt |
| irq_n_o | output | 1 | Active-low interrupt pin |

## Verification
The bench builds the block with NUM_CH = 8 and SYNC_STAGES = 2. The eight-bit registers hold distinct, non-trivial patterns, so a partial clear or a write that slips through during shutdown shows up in the data. The two-stage synchronizer gives the flag path a fixed, known latency. That latency lets the bench place an end-of-interrupt strobe in the exact cycle where an edge is captured, and check that a cool-down flag raised while stage 2 is still high does not release the shutdown.

// File: rtl/thermsup_pkg.sv
// Package: shared definitions for the thermal supervisor.
// Assumes: the flag ordering below is used wherever the three sensor
// flags travel together as one vector.
package thermsup_pkg;

    // Bit positions of the sensor flags inside the synchronized vector.
    localparam int FLAG_WARN = 0;
    localparam int FLAG_CRIT = 1;
    localparam int FLAG_COOL = 2;
    localparam int NUM_FLAGS = 3;

    // Stored interrupt indices.
    localparam int IRQ_WARN = 0;
    localparam int IRQ_CRIT = 1;
    localparam int NUM_IRQS = 2;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
    typedef logic [NUM_IRQS-1:0]  irq_vec_t;

endpackage

// File: rtl/thermsup_sync.sv
// Module: thermsup_sync
// Brings asynchronous comparator flags into the clock domain through a
// register chain of STAGES flops. STAGES = 0 passes the flags straight
// through.
// Assumes: each flag is a slow level that stays stable for well over
// STAGES cycles; no bus coherency is needed across bits.
module thermsup_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            // Purpose: no synchronization requested.
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stage_q;

            // Purpose: shift the flags through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    for (int i = STAGES - 1; i > 0; i--) begin
                        stage_q[i] <= stage_q[i-1];
                    end
                    stage_q[0] <= d_i;
                end
            end

            assign q_o = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/thermsup_irq_cell.sv
// Module: thermsup_irq_cell
// One stored interrupt. It is set by a 0-to-1 change of its level input
// and cleared by the end-of-interrupt strobe. When both happen in the
// same cycle, the set wins.
// Assumes: level_i is already synchronous to clk.
module thermsup_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic eoi_i,
    output logic pend_o
);

    logic level_prev_q;
    logic pend_q;
    logic rise;

    assign rise = level_i & ~level_prev_q;

    // Purpose: remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev_q <= 1'b0;
        else        level_prev_q <= level_i;
    end

    // Purpose: hold the pending flag, with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (rise)  pend_q <= 1'b1;
        else if (eoi_i) pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/thermsup_shutdown.sv
// Module: thermsup_shutdown
// Shutdown latch. It is set whenever the stage-2 flag is high and
// released only once the cool-down flag is high while stage 2 is low.
// Assumes: both inputs are synchronous to clk.
module thermsup_shutdown (
    input  logic clk,
    input  logic rst_n,
    input  logic crit_i,
    input  logic cool_i,
    output logic active_o
);

    logic active_q;

    // Purpose: set/release the shutdown state; stage 2 takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      active_q <= 1'b0;
        else if (crit_i) active_q <= 1'b1;
        else if (cool_i) active_q <= 1'b0;
    end

    assign active_o = active_q;

endmodule

// File: rtl/thermsup_chan_reg.sv
// Module: thermsup_chan_reg
// One per-channel host register. It is loaded by a write strobe and
// forced to zero while kill_i is high. A write in a killed cycle is
// dropped.
// Assumes: kill_i is synchronous to clk.
module thermsup_chan_reg #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill_i,
    input  logic              we_i,
    input  logic [NUM_CH-1:0] wdata_i,
    output logic [NUM_CH-1:0] q_o
);

    logic [NUM_CH-1:0] q;

    // Purpose: register update with the kill path ahead of host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (kill_i) q <= '0;
        else if (we_i)   q <= wdata_i;
    end

    assign q_o = q;

endmodule

// File: rtl/thermal_supervisor.sv
// Module: thermal_supervisor (top)
// Two-stage thermal supervisor. Stage 1 records a warning interrupt.
// Stage 2 records a shutdown interrupt, turns off the current sources and
// clears the output and flash-enable registers. The sources return on
// cool-down; the registers wait for the host to rewrite them.
// Assumes: comparator flags are asynchronous levels; eoi_i and the
// write strobes are single-cycle pulses synchronous to clk.
module thermal_supervisor #(
    parameter int NUM_CH      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_warn_i,
    input  logic              temp_crit_i,
    input  logic              temp_cool_i,
    input  logic              eoi_i,
    input  logic              out_we_i,
    input  logic [NUM_CH-1:0] out_wdata_i,
    input  logic              flash_we_i,
    input  logic [NUM_CH-1:0] flash_wdata_i,
    output logic [NUM_CH-1:0] out_q_o,
    output logic [NUM_CH-1:0] flash_q_o,
    output logic              src_en_o,
    output logic              warn_stat_o,
    output logic              crit_stat_o,
    output logic              warn_irq_o,
    output logic              crit_irq_o,
    output logic              irq_n_o
);

    import thermsup_pkg::*;

    flag_vec_t flags_raw;
    flag_vec_t flags_s;
    irq_vec_t  irq_level;
    irq_vec_t  irq_pend;
    logic      warn_s;
    logic      crit_s;
    logic      cool_s;
    logic      shut_active;
    logic      kill;

    // Purpose: pack the raw sensor flags in package order.
    always_comb begin
        flags_raw            = '0;
        flags_raw[FLAG_WARN] = temp_warn_i;
        flags_raw[FLAG_CRIT] = temp_crit_i;
        flags_raw[FLAG_COOL] = temp_cool_i;
    end

    thermsup_sync #(
        .WIDTH  (NUM_FLAGS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (flags_raw),
        .q_o   (flags_s)
    );

    assign warn_s = flags_s[FLAG_WARN];
    assign crit_s = flags_s[FLAG_CRIT];
    assign cool_s = flags_s[FLAG_COOL];

    // Purpose: route each stage flag to its interrupt cell.
    always_comb begin
        irq_level           = '0;
        irq_level[IRQ_WARN] = warn_s;
        irq_level[IRQ_CRIT] = crit_s;
    end

    generate
        for (genvar g = 0; g < NUM_IRQS; g++) begin : g_irq
            thermsup_irq_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .level_i (irq_level[g]),
                .eoi_i   (eoi_i),
                .pend_o  (irq_pend[g])
            );
        end
    endgenerate

    thermsup_shutdown u_shut (
        .clk      (clk),
        .rst_n    (rst_n),
        .crit_i   (crit_s),
        .cool_i   (cool_s),
        .active_o (shut_active)
    );

    // Clear the registers on the very edge that stage 2 is seen, and for
    // as long as the latch holds.
    assign kill = crit_s | shut_active;

    thermsup_chan_reg #(.NUM_CH(NUM_CH)) u_out_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill_i  (kill),
        .we_i    (out_we_i),
        .wdata_i (out_wdata_i),
        .q_o     (out_q_o)
    );

    thermsup_chan_reg #(.NUM_CH(NUM_CH)) u_flash_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill_i  (kill),
        .we_i    (flash_we_i),
        .wdata_i (flash_wdata_i),
        .q_o     (flash_q_o)
    );

    assign src_en_o    = ~shut_active;
    assign warn_stat_o = warn_s;
    assign crit_stat_o = crit_s;
    assign warn_irq_o  = irq_pend[IRQ_WARN];
    assign crit_irq_o  = irq_pend[IRQ_CRIT];
    assign irq_n_o     = ~(|irq_pend);

endmodule

// File: rtl/thermsup_checker.sv
// Module: thermsup_checker
// Temporal properties of the thermal supervisor, bound to the top.
// Assumes: rst_n is held low for at least one clock edge at start-up.
module thermsup_checker #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eoi_i,
    input logic              cool_s,
    input logic              src_en_o,
    input logic              warn_stat_o,
    input logic              crit_stat_o,
    input logic              warn_irq_o,
    input logic              crit_irq_o,
    input logic [NUM_CH-1:0] out_q_o,
    input logic [NUM_CH-1:0] flash_q_o
);

    p_warn_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_irq_o) |-> $past(warn_stat_o));

    p_crit_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crit_irq_o) |-> $past(crit_stat_o));

    p_eoi_warn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !warn_stat_o) |=> !warn_irq_o);

    p_eoi_crit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !crit_stat_o) |=> !crit_irq_o);

    p_warn_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn_irq_o) |-> $past(eoi_i));

    p_src_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        crit_stat_o |=> !src_en_o);

    p_regs_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en_o |=> (out_q_o == '0 && flash_q_o == '0));

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_en_o) |-> ($past(cool_s) && !$past(crit_stat_o)));

    p_cold_regs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_en_o) |-> (out_q_o == '0 && flash_q_o == '0));

endmodule

bind thermal_supervisor thermsup_checker #(.NUM_CH(NUM_CH)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoi_i       (eoi_i),
    .cool_s      (cool_s),
    .src_en_o    (src_en_o),
    .warn_stat_o (warn_stat_o),
    .crit_stat_o (crit_stat_o),
    .warn_irq_o  (warn_irq_o),
    .crit_irq_o  (crit_irq_o),
    .out_q_o     (out_q_o),
    .flash_q_o   (flash_q_o)
);

// File: tb/tb_thermal_supervisor.sv
`timescale 1ns/1ps
module tb_thermal_supervisor;

    localparam int NUM_CH      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int SETTLE      = SYNC_STAGES + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              temp_warn_i = 1'b0;
    logic              temp_crit_i = 1'b0;
    logic              temp_cool_i = 1'b0;
    logic              eoi_i = 1'b0;
    logic              out_we_i = 1'b0;
    logic [NUM_CH-1:0] out_wdata_i = '0;
    logic              flash_we_i = 1'b0;
    logic [NUM_CH-1:0] flash_wdata_i = '0;
    logic [NUM_CH-1:0] out_q_o;
    logic [NUM_CH-1:0] flash_q_o;
    logic              src_en_o;
    logic              warn_stat_o;
    logic              crit_stat_o;
    logic              warn_irq_o;
    logic              crit_irq_o;
    logic              irq_n_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    thermal_supervisor #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_eoi();
        eoi_i = 1'b1;
        @(negedge clk);
        eoi_i = 1'b0;
    endtask

    task automatic write_regs(input bit do_out, input logic [NUM_CH-1:0] ov,
                              input bit do_fl, input logic [NUM_CH-1:0] fv);
        out_we_i = do_out; out_wdata_i = ov;
        flash_we_i = do_fl; flash_wdata_i = fv;
        @(negedge clk);
        out_we_i = 1'b0; flash_we_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 src_en", src_en_o, 1);
        chk("R1 out", out_q_o, 0);
        chk("R1 flash", flash_q_o, 0);
        chk("R1 irqs", {warn_irq_o, crit_irq_o}, 0);
        chk("R1 irq_n", irq_n_o, 1);
    endtask

    task automatic t_writes();
        write_regs(1, 8'hA5, 0, 8'h00);
        chk("R13 out load", out_q_o, 8'hA5);
        chk("R13 flash untouched", flash_q_o, 8'h00);
        write_regs(0, 8'hFF, 1, 8'h3C);
        chk("R13 flash load", flash_q_o, 8'h3C);
        chk("R13 out untouched", out_q_o, 8'hA5);
    endtask

    task automatic t_warning();
        temp_warn_i = 1'b1;
        @(negedge clk);
        chk("R2 stat latency", warn_stat_o, 0);
        settle(SYNC_STAGES - 1);
        chk("R2 stat follows", warn_stat_o, 1);
        settle(2);
        chk("R3 warn irq", warn_irq_o, 1);
        chk("R6 pin low", irq_n_o, 0);
        chk("R3 sources kept", src_en_o, 1);
        chk("R3 out kept", out_q_o, 8'hA5);
        chk("R3 flash kept", flash_q_o, 8'h3C);
    endtask

    task automatic t_eoi_level();
        pulse_eoi();
        chk("R6 eoi clears", warn_irq_o, 0);
        chk("R6 pin high", irq_n_o, 1);
        settle(5);
        chk("R5 no refire", warn_irq_o, 0);
        temp_warn_i = 1'b0;
        settle(SETTLE);
        chk("R2 stat falls", warn_stat_o, 0);
        temp_warn_i = 1'b1;
        settle(SETTLE);
        chk("R5 new edge", warn_irq_o, 1);
        temp_warn_i = 1'b0;
        settle(SETTLE);
        pulse_eoi();
        chk("R6 cleared again", warn_irq_o, 0);
    endtask

    task automatic t_collision();
        // Flag enters sync at edge e0, reaches stat at e1, captured at e2.
        temp_warn_i = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        eoi_i = 1'b1;
        @(negedge clk);
        eoi_i = 1'b0;
        chk("R7 set wins", warn_irq_o, 1);
        pulse_eoi();
        chk("R7 later eoi clears", warn_irq_o, 0);
        temp_warn_i = 1'b0;
        settle(SETTLE);
    endtask

    task automatic t_shutdown();
        temp_warn_i = 1'b1;
        temp_crit_i = 1'b1;
        settle(SETTLE);
        chk("R2 crit stat", crit_stat_o, 1);
        chk("R4 crit irq", crit_irq_o, 1);
        chk("R8 sources off", src_en_o, 0);
        chk("R8 out cleared", out_q_o, 0);
        chk("R8 flash cleared", flash_q_o, 0);
        write_regs(1, 8'hFF, 1, 8'h81);
        chk("R9 out write ignored", out_q_o, 0);
        chk("R9 flash write ignored", flash_q_o, 0);
        pulse_eoi();
        chk("R6 crit cleared", crit_irq_o, 0);
        chk("R6 pin idle", irq_n_o, 1);
        temp_cool_i = 1'b1;
        settle(SETTLE);
        chk("R10 hold while crit", src_en_o, 0);
        temp_crit_i = 1'b0;
        temp_warn_i = 1'b0;
        settle(SETTLE);
        chk("R10 released", src_en_o, 1);
        chk("R11 out stays zero", out_q_o, 0);
        chk("R11 flash stays zero", flash_q_o, 0);
        write_regs(1, 8'h5A, 1, 8'h24);
        chk("R11 out rewrite", out_q_o, 8'h5A);
        chk("R11 flash rewrite", flash_q_o, 8'h24);
    endtask

    task automatic t_cool_paths();
        temp_cool_i = 1'b0;
        settle(SETTLE);
        temp_cool_i = 1'b1;
        settle(SETTLE);
        chk("R12 sources", src_en_o, 1);
        chk("R12 out", out_q_o, 8'h5A);
        chk("R12 flash", flash_q_o, 8'h24);
        temp_cool_i = 1'b0;
        temp_crit_i = 1'b1;
        settle(SETTLE);
        temp_crit_i = 1'b0;
        settle(SETTLE);
        chk("R10 no cool no release", src_en_o, 0);
        temp_cool_i = 1'b1;
        settle(SETTLE);
        chk("R10 cool releases", src_en_o, 1);
        pulse_eoi();
        chk("R6 final pin", irq_n_o, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_writes();
        t_warning();
        t_eoi_level();
        t_collision();
        t_shutdown();
        t_cool_paths();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule